// File: doc/BRIEF.md
# Four-Channel Compare/PWM Timer

This block holds four independent 16-bit up-counters, each driving one output pin, behind a plain 16-bit register bus with byte addresses. For every channel, software chooses three things: a clock divider with a count edge, an optional compare register whose match clears the counter, and a pin behaviour. In the normal mode, a match on the first compare register acts on the pin. In the PWM mode, the period compare register also puts the pin back to its idle level. Every compare register has a sticky match flag.

One shared run register starts and halts all channels. While a channel is halted, its counter keeps its value and its pin shows the idle level programmed for it. A typical PWM set-up is as follows: halt the channel, program the divider, set the clear source to compare B, program compare A (duty) and compare B (period), select PWM mode, then set the run bit.

Top module: `tpu_pwm_unit`

## Requirements
- R1: After reset the run register reads 0, every control, mode, pin-control, enable, status and counter register reads 0, every compare register reads 0xFFFF, and all pins are 0.
- R2: The run register sits at address 0x00, and bit n runs channel n. The window of channel n starts at 0x10 + n*0x40. Within it the offsets are: control 0x00, mode 0x04, pin control 0x08, enable 0x0C, status 0x10, counter 0x14, compare A/B/C/D 0x18/0x1C/0x20/0x24. Any other address reads 0.
- R3: Control bits [2:0] set the divider: 0 gives /1, 1 gives /4, 2 gives /16, 3 gives /64. Control bits [4:3] set the count edge: 0 rising, 1 falling, 2 both. For a divider of D, once the run bit is set, rising counts on running cycles D, 2D, and so on; falling counts on cycles D/2, D/2+D, and so on; both counts every D/2 cycles.
- R4: A running channel advances its counter once per count tick. A halted channel keeps its counter value. A write to the counter loads it directly.
- R5: When the clear source is 0 (none), the counter wraps from 0xFFFF to 0.
- R6: Control bits [7:5] choose the clear source: 1 = A, 2 = B, 5 = C, 6 = D. On a tick where the counter equals the chosen compare register, the counter returns to 0, so the cycle length is that value plus 1 ticks.
- R7: Status bits 0..3 latch a match on A..D. Writing 0 to a status bit clears it. Writing 1 leaves it unchanged. A new match wins over a clear in the same cycle.
- R8: While halted, the pin equals pin-control bit 2 (the idle level). A write to that bit reaches the pin on the clock edge that stores it.
- R9: In normal mode (mode bits [3:0] = 0), a match on A applies pin-control bits [1:0] to the pin: 0 hold, 1 drive 0, 2 drive 1, 3 toggle. A match on B has no effect on the pin.
- R10: In PWM mode (mode bits [3:0] = 2) with clear on B, the pin holds its idle level from count 0 up to and including the A match tick. It then takes the A action, and returns to the idle level on the B match tick.
- R11: Mode bits 4..6 are stored and read back, but do not change behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One output pin per channel |

## Verification
The counter is run under every divider together with each count edge, and the final counts tell the rising, falling and both-edge tick phases apart. Free-running wrap and clearing on A, C and D are each run for one fixed number of ticks, so each clear source gives a different residue. Pin waveforms are sampled every cycle for three settings: PWM with a set action, PWM with a clear action and an inverted idle level, and normal-mode toggling with a B value that would disturb the pin if B acted in normal mode. These samples tell the PWM return-on-B behaviour apart from normal-mode behaviour.

// File: rtl/tpu_pkg.sv
package tpu_pkg;

    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 8;
    localparam int PRE_W    = 6;
    localparam int N_CMP    = 4;
    localparam logic [ADDR_W-1:0] RUN_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] WIN_BASE = 8'h10;
    localparam logic [3:0]        LAST_SEL = 4'd9;

    typedef enum logic [3:0] {
        RG_CTRL = 4'd0,
        RG_MODE = 4'd1,
        RG_IOC  = 4'd2,
        RG_IER  = 4'd3,
        RG_STAT = 4'd4,
        RG_CNT  = 4'd5,
        RG_GRA  = 4'd6,
        RG_GRB  = 4'd7,
        RG_GRC  = 4'd8,
        RG_GRD  = 4'd9
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LO   = 2'd1,
        ACT_HI   = 2'd2,
        ACT_TGL  = 2'd3
    } match_act_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_RSVD = 2'd3
    } cnt_edge_e;

    typedef struct packed {
        logic [2:0] clr_src;
        cnt_edge_e  edge_sel;
        logic [2:0] div_sel;
    } ctrl_t;

    typedef struct packed {
        logic       idle_lvl;
        match_act_e a_act;
    } pinctl_t;

    typedef struct packed {
        logic       hit_run;
        logic       hit_ch;
        logic [1:0] ch;
        reg_sel_e   sel;
    } dec_t;

    localparam logic [3:0] MODE_NORMAL = 4'd0;
    localparam logic [3:0] MODE_PWM    = 4'd2;

    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
        case (code)
            3'd0:    div_limit = 6'd0;
            3'd1:    div_limit = 6'd3;
            3'd2:    div_limit = 6'd15;
            default: div_limit = 6'd63;
        endcase
    endfunction

    function automatic logic [N_CMP-1:0] clr_mask(input logic [2:0] src);
        case (src)
            3'd1:    clr_mask = 4'b0001;
            3'd2:    clr_mask = 4'b0010;
            3'd5:    clr_mask = 4'b0100;
            3'd6:    clr_mask = 4'b1000;
            default: clr_mask = 4'b0000;
        endcase
    endfunction

    function automatic logic apply_act(input match_act_e act, input logic cur);
        case (act)
            ACT_LO:  apply_act = 1'b0;
            ACT_HI:  apply_act = 1'b1;
            ACT_TGL: apply_act = ~cur;
            default: apply_act = cur;
        endcase
    endfunction

endpackage

// File: rtl/tpu_addr_dec.sv
module tpu_addr_dec
    import tpu_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output dec_t              dec
);
    logic [ADDR_W-1:0] off;
    logic [3:0]        sel_raw;

    always_comb begin
        off         = bus_addr - WIN_BASE;
        sel_raw     = off[5:2];
        dec.hit_run = (bus_addr == RUN_ADDR);
        dec.hit_ch  = (bus_addr >= WIN_BASE) && (off[1:0] == 2'b00) &&
                      (sel_raw <= LAST_SEL) && (int'(off[7:6]) < NUM_CH);
        dec.ch      = off[7:6];
        dec.sel     = reg_sel_e'(sel_raw);
    end
endmodule

// File: rtl/tpu_prescaler.sv
module tpu_prescaler
    import tpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] div_sel,
    input  cnt_edge_e  edge_sel,
    output logic       tick
);
    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] half;
    logic             at_rise;
    logic             at_fall;

    always_comb begin
        limit   = div_limit(div_sel);
        half    = limit >> 1;
        at_rise = (pc_q == limit);
        at_fall = (pc_q == half);
        if (!run) begin
            tick = 1'b0;
        end else if (limit == '0) begin
            tick = 1'b1;
        end else begin
            case (edge_sel)
                EDGE_FALL: tick = at_fall;
                EDGE_BOTH: tick = at_rise | at_fall;
                default:   tick = at_rise;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pc_q <= '0;
        end else if (pc_q >= limit) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick); // R3
endmodule

// File: rtl/tpu_channel.sv
module tpu_channel
    import tpu_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             pin
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    ctrl_t            ctrl_q;
    logic [6:0]       mode_q;
    pinctl_t          pinctl_q;
    logic [3:0]       ier_q;
    logic [N_CMP-1:0] stat_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    cmp_q [N_CMP];
    logic             pin_q;

    logic             tick;
    logic             adv;
    logic [N_CMP-1:0] hit;
    logic             clr_now;
    logic             pwm_mode;
    logic             cnt_wr;
    logic             pinctl_wr;
    logic             stat_wr;
    logic [N_CMP-1:0] stat_nx;

    tpu_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div_sel  (ctrl_q.div_sel),
        .edge_sel (ctrl_q.edge_sel),
        .tick     (tick)
    );

    assign adv = run & tick;

    genvar g;
    generate
        for (g = 0; g < N_CMP; g++) begin : g_cmp
            assign hit[g] = adv && (cnt_q == cmp_q[g]);
        end
    endgenerate

    always_comb begin
        clr_now   = |(hit & clr_mask(ctrl_q.clr_src));
        pwm_mode  = (mode_q[3:0] == MODE_PWM);
        cnt_wr    = wr && (sel == RG_CNT);
        pinctl_wr = wr && (sel == RG_IOC);
        stat_wr   = wr && (sel == RG_STAT);
        stat_nx   = (stat_wr ? (stat_q & wdata[N_CMP-1:0]) : stat_q) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            mode_q   <= '0;
            pinctl_q <= '0;
            ier_q    <= '0;
            for (int i = 0; i < N_CMP; i++) cmp_q[i] <= '1;
        end else if (wr) begin
            case (sel)
                RG_CTRL: ctrl_q   <= ctrl_t'(wdata[7:0]);
                RG_MODE: mode_q   <= wdata[6:0];
                RG_IOC:  pinctl_q <= pinctl_t'(wdata[2:0]);
                RG_IER:  ier_q    <= wdata[3:0];
                RG_GRA:  cmp_q[0] <= wdata[CW-1:0];
                RG_GRB:  cmp_q[1] <= wdata[CW-1:0];
                RG_GRC:  cmp_q[2] <= wdata[CW-1:0];
                RG_GRD:  cmp_q[3] <= wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            stat_q <= '0;
            pin_q  <= 1'b0;
        end else begin
            stat_q <= stat_nx;
            if (cnt_wr) begin
                cnt_q <= wdata[CW-1:0];
            end else if (adv) begin
                cnt_q <= clr_now ? '0 : cnt_q + 1'b1;
            end
            if (!run) begin
                pin_q <= pinctl_wr ? wdata[2] : pinctl_q.idle_lvl;
            end else if (pwm_mode && hit[1]) begin
                pin_q <= pinctl_q.idle_lvl;
            end else if (hit[0]) begin
                pin_q <= apply_act(pinctl_q.a_act, pin_q);
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            RG_CTRL: rdata[7:0]       = ctrl_q;
            RG_MODE: rdata[6:0]       = mode_q;
            RG_IOC:  rdata[2:0]       = pinctl_q;
            RG_IER:  rdata[3:0]       = ier_q;
            RG_STAT: rdata[N_CMP-1:0] = stat_q;
            RG_CNT:  rdata[CW-1:0]    = cnt_q;
            RG_GRA:  rdata[CW-1:0]    = cmp_q[0];
            RG_GRB:  rdata[CW-1:0]    = cmp_q[1];
            RG_GRC:  rdata[CW-1:0]    = cmp_q[2];
            RG_GRD:  rdata[CW-1:0]    = cmp_q[3];
            default: rdata = '0;
        endcase
    end

    assign pin = pin_q;

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt_q)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_q == CNT_MAX && ctrl_q.clr_src == 3'd0 && !cnt_wr) |=> (cnt_q == '0)); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr_now && !cnt_wr) |=> (cnt_q == '0)); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        hit[0] |=> stat_q[0]); // R7
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run && !pinctl_wr) |=> (pin_q == pinctl_q.idle_lvl)); // R8
endmodule

// File: rtl/tpu_pwm_unit.sv
module tpu_pwm_unit
    import tpu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    dec_t              dec;
    logic [NUM_CH-1:0] run_q;
    logic [NUM_CH-1:0] wr_mask;
    logic [BUS_W-1:0]  ch_rdata [NUM_CH];
    logic [BUS_W-1:0]  run_rd;
    logic              run_wr;

    tpu_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
        .bus_addr (bus_addr),
        .dec      (dec)
    );

    assign run_wr = bus_wr && dec.hit_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (run_wr) begin
            run_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            assign wr_mask[c] = bus_wr && dec.hit_ch && (dec.ch == 2'(c));
            tpu_channel #(.CW(CW)) u_ch (
                .clk   (clk),
                .rst   (rst),
                .run   (run_q[c]),
                .wr    (wr_mask[c]),
                .sel   (dec.sel),
                .wdata (bus_wdata),
                .rdata (ch_rdata[c]),
                .pin   (pwm_out[c])
            );
        end
    endgenerate

    always_comb begin
        run_rd = '0;
        run_rd[NUM_CH-1:0] = run_q;
        if (dec.hit_run) begin
            bus_rdata = run_rd;
        end else if (dec.hit_ch) begin
            bus_rdata = ch_rdata[dec.ch];
        end else begin
            bus_rdata = '0;
        end
    end

    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_mask)); // R2
    AST_RUN_KEEP: assert property (@(posedge clk) disable iff (rst)
        !run_wr |=> $stable(run_q)); // R2
endmodule

// File: tb/tpu_pwm_unit_tb.sv
module tpu_pwm_unit_tb_top;

    localparam int NCH = 4;
    localparam logic [7:0] A_RUN = 8'h00;
    localparam logic [7:0] O_CTRL = 8'h00, O_MODE = 8'h04, O_IOC = 8'h08,
                           O_STAT = 8'h10, O_CNT = 8'h14, O_GRA = 8'h18,
                           O_GRB = 8'h1C, O_GRC = 8'h20, O_GRD = 8'h24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [15:0]      bus_wdata = '0;
    logic [15:0]      bus_rdata;
    logic [NCH-1:0]   pwm_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit          is_pin;
        int          pin_idx;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  smp;

    always #5 clk = ~clk;

    tpu_pwm_unit #(.NUM_CH(NCH), .CW(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [7:0] ca(input int ch, input logic [7:0] ofs);
        return 8'h10 + 8'(ch * 64) + ofs;
    endfunction

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            @(smp);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                act = it.is_pin ? 16'(pwm_out[it.pin_idx]) : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [15:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_pin = 0; it.pin_idx = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> smp;
        #2;
    endtask

    task automatic chk_pin(input int idx, input logic e, input string tag);
        item_t it;
        it.is_pin = 1; it.pin_idx = idx; it.exp = 16'(e); it.tag = tag;
        sb_q.push_back(it);
        -> smp;
        #2;
    endtask

    task automatic run_count(input logic [15:0] ctrl, input int n, input logic [15:0] e,
                             input string tag);
        wr(ca(0, O_CTRL), ctrl);
        wr(ca(0, O_CNT), 16'h0000);
        wr(A_RUN, 16'h0001);
        repeat (n) @(negedge clk);
        wr(A_RUN, 16'h0000);
        chk_rd(ca(0, O_CNT), e, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_rd(A_RUN, 16'h0000, "R1 run reg");
        chk_rd(ca(0, O_CTRL), 16'h0000, "R1 ctrl");
        chk_rd(ca(1, O_CNT), 16'h0000, "R1 counter");
        chk_rd(ca(3, O_GRB), 16'hFFFF, "R1 compare B");
        chk_pin(0, 1'b0, "R1 pin0");
        chk_pin(3, 1'b0, "R1 pin3");

        // R2 decode and readback
        wr(ca(3, O_GRD), 16'hBEEF);
        chk_rd(ca(3, O_GRD), 16'hBEEF, "R2 ch3 compare D");
        chk_rd(ca(2, O_GRD), 16'hFFFF, "R2 ch2 untouched");
        chk_rd(8'h38, 16'h0000, "R2 unmapped offset");
        chk_rd(8'h04, 16'h0000, "R2 unmapped low");

        // R3/R4 divider and edge
        run_count(16'h0000, 10, 16'd11, "R4 div1 count");
        repeat (5) @(negedge clk);
        chk_rd(ca(0, O_CNT), 16'd11, "R4 halted holds");
        run_count(16'h0001, 40, 16'd10, "R3 div4 rising");
        run_count(16'h000A, 40, 16'd3, "R3 div16 falling");
        run_count(16'h0011, 40, 16'd20, "R3 div4 both");
        run_count(16'h0003, 130, 16'd2, "R3 div64 rising");

        // R5 wrap, R7 status
        wr(ca(0, O_CTRL), 16'h0000);
        wr(ca(0, O_CNT), 16'hFFFD);
        chk_rd(ca(0, O_CNT), 16'hFFFD, "R4 load");
        wr(A_RUN, 16'h0001);
        repeat (5) @(negedge clk);
        wr(A_RUN, 16'h0000);
        chk_rd(ca(0, O_CNT), 16'h0003, "R5 wrap");
        chk_rd(ca(0, O_STAT), 16'h000F, "R7 flags set");
        wr(ca(0, O_STAT), 16'h000E);
        chk_rd(ca(0, O_STAT), 16'h000E, "R7 clear bit0");
        wr(ca(0, O_STAT), 16'h0000);
        chk_rd(ca(0, O_STAT), 16'h0000, "R7 clear all");

        // R6 clear sources
        wr(ca(0, O_GRA), 16'd4);
        run_count(16'h0020, 13, 16'd4, "R6 clear on A");
        chk_rd(ca(0, O_STAT), 16'h0001, "R7 A flag only");
        wr(ca(0, O_GRC), 16'd2);
        run_count(16'h00A0, 13, 16'd2, "R6 clear on C");
        wr(ca(0, O_GRD), 16'd6);
        run_count(16'h00C0, 13, 16'd0, "R6 clear on D");

        // R10 PWM on channel 2, idle 0, A drives 1
        wr(ca(2, O_IOC), 16'h0002);
        wr(ca(2, O_GRA), 16'd2);
        wr(ca(2, O_GRB), 16'd5);
        wr(ca(2, O_CTRL), 16'h0040);
        wr(ca(2, O_MODE), 16'h0002);
        chk_pin(2, 1'b0, "R8 halted idle 0");
        wr(A_RUN, 16'h0004);
        for (int k = 0; k < 12; k++) begin
            chk_pin(2, (k % 6) >= 3, $sformatf("R10 pwm set k=%0d", k));
            @(negedge clk);
        end
        wr(A_RUN, 16'h0000);
        chk_pin(2, 1'b0, "R8 halt returns idle");
        wr(ca(2, O_IOC), 16'h0005);
        chk_pin(2, 1'b1, "R8 idle write reaches pin");
        wr(ca(2, O_CNT), 16'h0000);
        wr(A_RUN, 16'h0004);
        for (int k = 0; k < 12; k++) begin
            chk_pin(2, !((k % 6) >= 3), $sformatf("R10 pwm inverted k=%0d", k));
            @(negedge clk);
        end
        wr(A_RUN, 16'h0000);

        // R11 buffer bits stored, no effect
        wr(ca(2, O_MODE), 16'h0072);
        chk_rd(ca(2, O_MODE), 16'h0072, "R11 mode readback");
        wr(ca(2, O_IOC), 16'h0002);
        wr(ca(2, O_CNT), 16'h0000);
        wr(A_RUN, 16'h0004);
        for (int k = 0; k < 6; k++) begin
            chk_pin(2, (k % 6) >= 3, $sformatf("R11 pwm unchanged k=%0d", k));
            @(negedge clk);
        end
        wr(A_RUN, 16'h0000);

        // R9 normal-mode toggle on channel 1; B match must not touch the pin
        wr(ca(1, O_GRA), 16'd3);
        wr(ca(1, O_GRB), 16'd1);
        wr(ca(1, O_IOC), 16'h0003);
        wr(ca(1, O_CTRL), 16'h0020);
        wr(A_RUN, 16'h0002);
        chk_rd(A_RUN, 16'h0002, "R2 run reg readback");
        for (int k = 0; k < 16; k++) begin
            chk_pin(1, ((k / 4) % 2) == 1, $sformatf("R9 toggle k=%0d", k));
            @(negedge clk);
        end
        wr(A_RUN, 16'h0000);

        #5;
        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending items", sb_q.size());
        end
        summary();
    end

endmodule